// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds eight 32-bit general-purpose registers behind two read ports and one write port. Each access names a register with a 3-bit index and a view with a 2-bit part selector. The view can be the whole word, the low halfword, or one byte of the low halfword. All views of a register share the same 32-bit storage, so a narrow write shows up in every wider view of that register.

Byte views exist only for registers 0 through 3. Index order is: 0 accumulator, 1 counter, 2 data, 3 base, 4 stack pointer, 5 frame base pointer, 6 source index, 7 destination index. A byte request to index 4 or above is refused. The port raises an error flag, and a refused write leaves storage unchanged.

Reads are combinational and return the selected field zero-extended. Writes take effect on the rising clock edge.

Top module: `gpr_alias_file`

## Requirements
- R1: Part code 00 selects the full 32-bit word. A write stores all of `wr_data_i` and a read returns all 32 bits.
- R2: Part code 01 selects bits 15:0. A write loads them from `wr_data_i[15:0]` and keeps bits 31:16.
- R3: Part code 10 selects bits 7:0 of registers 0 to 3. A write loads them from `wr_data_i[7:0]` and keeps bits 31:8.
- R4: Part code 11 selects bits 15:8 of registers 0 to 3. A write loads them from `wr_data_i[7:0]` and keeps bits 31:16 and 7:0.
- R5: A read with part code 01, 10 or 11 returns the selected field in the low bits of the read data, with every other bit zero.
- R6: A part code of 10 or 11 with an index of 4 to 7 is illegal. A read then raises its error flag and returns zero. A write then raises `wr_err_o` and changes no register.
- R7: Writes take effect on the rising clock edge. A read of the register being written in the same cycle returns the value it had before that edge.
- R8: While `rst_ni` is low, all eight registers read as zero.
- R9: A write changes only the register it addresses; the other seven keep their values.
- R10: The two read ports are independent. Each returns its own register and view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 3 | Write register index |
| wr_part_i | input | 2 | Write part selector |
| wr_data_i | input | 32 | Write data, field taken from the low bits |
| wr_err_o | output | 1 | Write request is illegal and was dropped |
| rd_a_idx_i | input | 3 | Read port A register index |
| rd_a_part_i | input | 2 | Read port A part selector |
| rd_a_data_o | output | 32 | Read port A data, zero-extended |
| rd_a_err_o | output | 1 | Read port A request is illegal |
| rd_b_idx_i | input | 3 | Read port B register index |
| rd_b_part_i | input | 2 | Read port B part selector |
| rd_b_data_o | output | 32 | Read port B data, zero-extended |
| rd_b_err_o | output | 1 | Read port B request is illegal |

## Verification
The assertions assume that every index, part selector and enable input carries a known 0 or 1 at each sampled edge. They also assume reset has been applied once before checking starts, so that every register holds a defined value.

The bench keeps within these assumptions. It drives every input to a known value in each cycle, from directed sequences or from `$urandom`, and it releases reset only after all inputs are defined. The random phase mixes all four part codes over all eight indices, so illegal byte requests occur regularly alongside legal ones.

// File: rtl/gpr_alias_pkg.sv
package gpr_alias_pkg;
  typedef enum logic [1:0] {
    PART_W32 = 2'b00,
    PART_W16 = 2'b01,
    PART_LO8 = 2'b10,
    PART_HI8 = 2'b11
  } part_e;
endpackage

// File: rtl/gpr_part_decode.sv
module gpr_part_decode #(
  parameter int XLEN      = 32,
  parameter int HALF_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 3,
  parameter int BYTE_REGS = 4,
  localparam int SH_W     = $clog2(XLEN)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       part_i,
  output logic             legal_o,
  output logic [XLEN-1:0]  mask_o,
  output logic [SH_W-1:0]  lsb_o
);
  import gpr_alias_pkg::*;

  localparam logic [XLEN-1:0] M16 = {{(XLEN-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [XLEN-1:0] M8  = {{(XLEN-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic byte_view;
  logic has_bytes;

  assign byte_view = part_i[1];
  assign has_bytes = (int'(idx_i) < BYTE_REGS);
  assign legal_o   = !byte_view || has_bytes;

  always_comb begin
    mask_o = '1;
    lsb_o  = '0;
    case (part_i)
      PART_W32: mask_o = '1;
      PART_W16: mask_o = M16;
      PART_LO8: mask_o = M8;
      PART_HI8: begin
        mask_o = M8 << BYTE_W;
        lsb_o  = SH_W'(BYTE_W);
      end
      default: mask_o = '1;
    endcase
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int XLEN      = 32,
  parameter int HALF_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int SH_W     = $clog2(XLEN)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_REGS-1:0][XLEN-1:0] regs_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [1:0]                    part_i,
  output logic [XLEN-1:0]               data_o,
  output logic                          err_o
);
  import gpr_alias_pkg::*;

  logic            legal;
  logic [XLEN-1:0] mask;
  logic [SH_W-1:0] lsb;
  logic [XLEN-1:0] word;

  gpr_part_decode #(
    .XLEN(XLEN), .HALF_W(HALF_W), .BYTE_W(BYTE_W),
    .IDX_W(IDX_W), .BYTE_REGS(BYTE_REGS)
  ) u_dec (
    .idx_i(idx_i), .part_i(part_i),
    .legal_o(legal), .mask_o(mask), .lsb_o(lsb)
  );

  assign word   = regs_i[idx_i];
  assign data_o = legal ? ((word & mask) >> lsb) : '0;
  assign err_o  = !legal;

  // narrow views come back zero-extended
  assert_zext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i != PART_W32) |-> (data_o[XLEN-1:HALF_W] == '0));
  assert_err_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (data_o == '0));
  assert_err_only_bytes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (part_i[1] && int'(idx_i) >= BYTE_REGS));
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge #(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int SH_W    = $clog2(XLEN)
) (
  input  logic [NUM_REGS-1:0][XLEN-1:0] regs_i,
  input  logic                          we_i,
  input  logic                          legal_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [XLEN-1:0]               mask_i,
  input  logic [SH_W-1:0]               lsb_i,
  input  logic [XLEN-1:0]               data_i,
  output logic [NUM_REGS-1:0][XLEN-1:0] regs_o
);
  logic [XLEN-1:0] field;

  assign field = (data_i << lsb_i) & mask_i;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_merge
    logic hit;
    assign hit       = we_i && legal_i && (idx_i == IDX_W'(i));
    assign regs_o[i] = hit ? ((regs_i[i] & ~mask_i) | field) : regs_i[i];
  end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file #(
  parameter int XLEN      = 32,
  parameter int HALF_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int SH_W     = $clog2(XLEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_part_i,
  input  logic [XLEN-1:0]  wr_data_i,
  output logic             wr_err_o,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [1:0]       rd_a_part_i,
  output logic [XLEN-1:0]  rd_a_data_o,
  output logic             rd_a_err_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  input  logic [1:0]       rd_b_part_i,
  output logic [XLEN-1:0]  rd_b_data_o,
  output logic             rd_b_err_o
);
  import gpr_alias_pkg::*;

  logic [NUM_REGS-1:0][XLEN-1:0] regs_q, regs_d;
  logic            wr_legal;
  logic [XLEN-1:0] wr_mask;
  logic [SH_W-1:0] wr_lsb;

  gpr_part_decode #(
    .XLEN(XLEN), .HALF_W(HALF_W), .BYTE_W(BYTE_W),
    .IDX_W(IDX_W), .BYTE_REGS(BYTE_REGS)
  ) u_wr_dec (
    .idx_i(wr_idx_i), .part_i(wr_part_i),
    .legal_o(wr_legal), .mask_o(wr_mask), .lsb_o(wr_lsb)
  );

  assign wr_err_o = wr_en_i && !wr_legal;

  gpr_write_merge #(.XLEN(XLEN), .NUM_REGS(NUM_REGS)) u_merge (
    .regs_i(regs_q), .we_i(wr_en_i), .legal_i(wr_legal), .idx_i(wr_idx_i),
    .mask_i(wr_mask), .lsb_i(wr_lsb), .data_i(wr_data_i), .regs_o(regs_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else         regs_q <= regs_d;
  end

  gpr_read_port #(
    .XLEN(XLEN), .HALF_W(HALF_W), .BYTE_W(BYTE_W),
    .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)
  ) u_rd_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .regs_i(regs_q),
    .idx_i(rd_a_idx_i), .part_i(rd_a_part_i),
    .data_o(rd_a_data_o), .err_o(rd_a_err_o)
  );

  gpr_read_port #(
    .XLEN(XLEN), .HALF_W(HALF_W), .BYTE_W(BYTE_W),
    .NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)
  ) u_rd_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .regs_i(regs_q),
    .idx_i(rd_b_idx_i), .part_i(rd_b_part_i),
    .data_o(rd_b_data_o), .err_o(rd_b_err_o)
  );

  assert_illegal_nowrite_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> $stable(regs_q));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    assert_others_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i || wr_idx_i != IDX_W'(i)) |=> $stable(regs_q[i]));
    assert_w16_upper_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(i) && wr_part_i == PART_W16)
      |=> $stable(regs_q[i][XLEN-1:HALF_W]));
    assert_lo8_upper_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(i) && wr_part_i == PART_LO8)
      |=> $stable(regs_q[i][XLEN-1:BYTE_W]));
    assert_hi8_rest_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(i) && wr_part_i == PART_HI8)
      |=> ($stable(regs_q[i][XLEN-1:HALF_W]) && $stable(regs_q[i][BYTE_W-1:0])));
  end
endmodule

// File: tb/sim_gpr_alias_file.sv
`timescale 1ns/1ps
module sim_gpr_alias_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_part = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err;
  logic [2:0]  a_idx = '0, b_idx = '0;
  logic [1:0]  a_part = '0, b_part = '0;
  logic [31:0] a_data, b_data;
  logic        a_err, b_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model [8];

  always #2 clk = ~clk;

  gpr_alias_file u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_part_i(wr_part), .wr_data_i(wr_data),
    .wr_err_o(wr_err),
    .rd_a_idx_i(a_idx), .rd_a_part_i(a_part), .rd_a_data_o(a_data), .rd_a_err_o(a_err),
    .rd_b_idx_i(b_idx), .rd_b_part_i(b_part), .rd_b_data_o(b_data), .rd_b_err_o(b_err)
  );

  function automatic bit illegal(input logic [2:0] idx, input logic [1:0] part);
    return part[1] && idx >= 3'd4;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] idx, input logic [1:0] part);
    logic [31:0] v = model[idx];
    if (illegal(idx, part)) return 32'h0;
    case (part)
      2'b00:   return v;
      2'b01:   return {16'h0, v[15:0]};
      2'b10:   return {24'h0, v[7:0]};
      default: return {24'h0, v[15:8]};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] part);
    case (part)
      2'b00:   return "R1";
      2'b01:   return "R2/R5";
      2'b10:   return "R3/R5";
      default: return "R4/R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_ports();
    string ta, tb;
    ta = illegal(a_idx, a_part) ? "R6" : tag_of(a_part);
    tb = illegal(b_idx, b_part) ? "R6" : tag_of(b_part);
    chk({ta, " port A data"}, a_data, exp_read(a_idx, a_part));
    chk({tb, " port B data R10"}, b_data, exp_read(b_idx, b_part));
    chk("R6 port A err", {31'h0, a_err}, {31'h0, illegal(a_idx, a_part)});
    chk("R6 port B err", {31'h0, b_err}, {31'h0, illegal(b_idx, b_part)});
    chk("R6 write err", {31'h0, wr_err}, {31'h0, wr_en && illegal(wr_idx, wr_part)});
  endtask

  task automatic model_update();
    logic [31:0] v;
    if (!wr_en || illegal(wr_idx, wr_part)) return;
    v = model[wr_idx];
    case (wr_part)
      2'b00:   v = wr_data;
      2'b01:   v[15:0] = wr_data[15:0];
      2'b10:   v[7:0] = wr_data[7:0];
      default: v[15:8] = wr_data[7:0];
    endcase
    model[wr_idx] = v;
  endtask

  // one cycle: drive at negedge, check combinational reads before the edge, update model at the edge
  task automatic step(input logic we, input logic [2:0] wi, input logic [1:0] wp,
                      input logic [31:0] wd, input logic [2:0] ai, input logic [1:0] ap,
                      input logic [2:0] bi, input logic [1:0] bp);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_part = wp; wr_data = wd;
    a_idx = ai; a_part = ap; b_idx = bi; b_part = bp;
    #1;
    check_ports();
    @(posedge clk);
    model_update();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    // R8: reset state on both ports
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      a_idx = 3'(i); a_part = 2'b00; b_idx = 3'(7 - i); b_part = 2'b01;
      #0.5;
      chk("R8 reset A", a_data, 32'h0);
      chk("R8 reset B", b_data, 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 full write and readback
    step(1, 3'd0, 2'b00, 32'hA1B2C3D4, 3'd0, 2'b00, 3'd1, 2'b00);
    step(1, 3'd5, 2'b00, 32'hDEADBEEF, 3'd0, 2'b00, 3'd0, 2'b01);
    // R2 halfword write keeps upper
    step(1, 3'd5, 2'b01, 32'hFFFF1234, 3'd5, 2'b00, 3'd5, 2'b01);
    step(0, 3'd0, 2'b00, 32'h0, 3'd5, 2'b00, 3'd5, 2'b01);
    chk("R2 upper kept", a_data, 32'hDEAD1234);
    // R3 low byte
    step(1, 3'd0, 2'b10, 32'hFFFFFF77, 3'd0, 2'b10, 3'd0, 2'b11);
    step(0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd0, 2'b10);
    chk("R3 low byte merged", a_data, 32'hA1B2C377);
    // R4 high byte from data[7:0]
    step(1, 3'd0, 2'b11, 32'h00000099, 3'd0, 2'b00, 3'd0, 2'b11);
    step(0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd0, 2'b11);
    chk("R4 high byte merged", a_data, 32'hA1B29977);
    chk("R4 high byte view", b_data, 32'h00000099);
    // R6 illegal byte write to index 6 changes nothing
    step(1, 3'd6, 2'b10, 32'h12345678, 3'd6, 2'b00, 3'd6, 2'b11);
    step(0, 3'd0, 2'b00, 32'h0, 3'd6, 2'b00, 3'd7, 2'b10);
    chk("R6 no write", a_data, 32'h0);
    // R7 same-cycle read returns old value
    @(negedge clk);
    wr_en = 1; wr_idx = 3'd3; wr_part = 2'b00; wr_data = 32'h0BADF00D;
    a_idx = 3'd3; a_part = 2'b00; b_idx = 3'd3; b_part = 2'b00;
    #1;
    chk("R7 old value before edge", a_data, 32'h0);
    @(posedge clk); model_update();
    @(negedge clk); wr_en = 0; #1;
    chk("R7 new value after edge", b_data, 32'h0BADF00D);
    // R9 neighbours untouched
    step(0, 3'd0, 2'b00, 32'h0, 3'd2, 2'b00, 3'd4, 2'b00);
    chk("R9 neighbour kept", a_data, 32'h0);

    // mixed random traffic, all part codes and indices
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 3) != 0, 3'($urandom), 2'($urandom), $urandom,
           3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom));
    end
    // final sweep of all registers, R9 state compare
    for (int i = 0; i < 8; i++)
      step(0, 3'd0, 2'b00, 32'h0, 3'(i), 2'b00, 3'(i), 2'b01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule